// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Engine

This engine copies a block of words between one peripheral and main memory, so that the processor does not have to touch each word. Software sets the direction, the peripheral number, the first memory address and the number of words through a small register interface, then writes a go bit. The engine waits until the selected peripheral says it is ready, asks for the system bus, moves one word once the bus is granted, and hands the bus back at once. It repeats this until no words are left, then raises an interrupt.

The processor keeps the bus between stolen cycles, so it only slows down and never has to save any state. One interrupt marks the end of the whole block. It stays raised until software reads the status register.

Top module: `cs_dma_ctrl`

## Requirements
- R1: The register offsets on `cfg_addr` are: 0 control (bit 0 go, bit 1 direction, where 1 means memory to peripheral and 0 means peripheral to memory), 1 peripheral number, 2 memory address, 3 word count, 4 status (bit 0 busy, bit 1 done). Offsets 2 and 3 read back the live address and the remaining count.
- R2: `dev_sel` always carries the programmed peripheral number.
- R3: `bus_req` rises only in the cycle after one in which `dev_ready` was high.
- R4: A word moves only in a cycle with `bus_ack` high that follows a cycle with `bus_req` high. Word k goes to memory address start+k. Peripheral-to-memory transfers drive `mem_we`=1 with `mem_wdata`=`dev_rd_data`. Memory-to-peripheral transfers drive `mem_we`=0 with `dev_wr_data`=`mem_rdata`. `mem_en` and `dev_strobe` pulse in that cycle.
- R5: Each period of bus ownership carries exactly one word. After each word the address rises by one and the count falls by one.
- R6: `bus_req` is low in the cycle after every word.
- R7: After the last word, `irq` goes high, status shows busy 0 and done 1, the address reads start+count and the count reads 0.
- R8: `irq` stays high until the status register is read. It is low from the cycle after that read.
- R9: A go with a count of zero raises `irq` in the next cycle and never asserts `bus_req`.
- R10: While busy, writes to the direction, peripheral, address and count registers, and to go, have no effect.
- R11: After reset, `irq`, `bus_req` and `mem_en` are low and status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data |
| dev_sel | output | DEVW | Selected peripheral |
| dev_ready | input | 1 | Selected peripheral ready |
| dev_rd_data | input | DW | Word from peripheral |
| dev_wr_data | output | DW | Word to peripheral |
| dev_strobe | output | 1 | Peripheral word taken or given |
| bus_req | output | 1 | System bus request |
| bus_ack | input | 1 | System bus grant |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, same cycle |
| irq | output | 1 | Block complete interrupt |

## Verification
The hardest cases to reach are register writes that arrive in the middle of a block, and a peripheral that stays not-ready for a long time. The bench starts a long block and then issues new address, count and go writes while busy. It then checks that the block still ends at the original address with the original word count. A directed phase holds `dev_ready` low for many cycles and checks that no bus request appears. Random grant delays and random peripheral readiness around these phases vary the spacing between stolen cycles.

// File: rtl/cs_dma_pkg.sv
`timescale 1ns/1ps
package cs_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_REQ,
    ST_MOVE,
    ST_RELEASE
  } dma_state_e;

  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] OFF_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] OFF_DEV   = 3'd1;
  localparam logic [REG_AW-1:0] OFF_ADDR  = 3'd2;
  localparam logic [REG_AW-1:0] OFF_COUNT = 3'd3;
  localparam logic [REG_AW-1:0] OFF_STAT  = 3'd4;
endpackage

// File: rtl/cs_dma_counter.sv
`timescale 1ns/1ps
module cs_dma_counter #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_addr,
  input  logic          ld_count,
  input  logic [AW-1:0] addr_in,
  input  logic [CW-1:0] count_in,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_count,
  output logic          count_zero
);
  localparam logic [AW-1:0] ADDR_ONE  = AW'(1);
  localparam logic [CW-1:0] COUNT_ONE = CW'(1);

  function automatic logic [AW-1:0] addr_inc(input logic [AW-1:0] a);
    return a + ADDR_ONE;
  endfunction

  function automatic logic [CW-1:0] count_dec(input logic [CW-1:0] c);
    return c - COUNT_ONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      cur_count <= '0;
    end else begin
      if (ld_addr)   cur_addr  <= addr_in;
      else if (step) cur_addr  <= addr_inc(cur_addr);
      if (ld_count)  cur_count <= count_in;
      else if (step) cur_count <= count_dec(cur_count);
    end
  end

  assign count_zero = (cur_count == '0);
endmodule

// File: rtl/cs_dma_regs.sv
`timescale 1ns/1ps
module cs_dma_regs import cs_dma_pkg::*; #(
  parameter int DW   = 16,
  parameter int AW   = 16,
  parameter int CW   = 16,
  parameter int DEVW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              busy,
  input  logic              fin,
  input  logic [AW-1:0]     cur_addr,
  input  logic [CW-1:0]     cur_count,
  output logic              go,
  output logic              dir,
  output logic [DEVW-1:0]   dev,
  output logic              ld_addr,
  output logic              ld_count,
  output logic [AW-1:0]     addr_in,
  output logic [CW-1:0]     count_in,
  output logic              irq,
  output logic [DW-1:0]     cfg_rdata
);
  logic wr_ok;
  logic done_q;
  logic status_clr;

  assign wr_ok      = cfg_wr && !busy;
  assign go         = wr_ok && (cfg_addr == OFF_CTRL) && cfg_wdata[0];
  assign ld_addr    = wr_ok && (cfg_addr == OFF_ADDR);
  assign ld_count   = wr_ok && (cfg_addr == OFF_COUNT);
  assign addr_in    = AW'(cfg_wdata);
  assign count_in   = CW'(cfg_wdata);
  assign status_clr = cfg_rd && (cfg_addr == OFF_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir <= 1'b0;
      dev <= '0;
    end else begin
      if (wr_ok && cfg_addr == OFF_CTRL) dir <= cfg_wdata[1];
      if (wr_ok && cfg_addr == OFF_DEV)  dev <= cfg_wdata[DEVW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          done_q <= 1'b0;
    else if (fin)        done_q <= 1'b1;
    else if (go)         done_q <= 1'b0;
    else if (status_clr) done_q <= 1'b0;
  end

  assign irq = done_q;

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      OFF_CTRL:  cfg_rdata[1] = dir;
      OFF_DEV:   cfg_rdata = DW'(dev);
      OFF_ADDR:  cfg_rdata = DW'(cur_addr);
      OFF_COUNT: cfg_rdata = DW'(cur_count);
      OFF_STAT:  cfg_rdata[1:0] = {done_q, busy};
      default:   cfg_rdata = '0;
    endcase
  end

  // R7
  done_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> irq);

  // R8
  irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !status_clr && !go) |=> irq);

  // R10
  busy_locks_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(dir) && $stable(dev)));
endmodule

// File: rtl/cs_dma_fsm.sv
`timescale 1ns/1ps
module cs_dma_fsm import cs_dma_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic count_zero,
  input  logic dev_ready,
  input  logic bus_ack,
  output logic busy,
  output logic bus_req,
  output logic xfer,
  output logic fin
);
  dma_state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    bus_req = 1'b0;
    xfer    = 1'b0;
    fin     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (go) begin
          if (count_zero) fin = 1'b1;
          else            state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (dev_ready) state_d = ST_REQ;
      end
      ST_REQ: begin
        bus_req = 1'b1;
        if (bus_ack) state_d = ST_MOVE;
      end
      ST_MOVE: begin
        bus_req = 1'b1;
        if (bus_ack) begin
          xfer    = 1'b1;
          state_d = ST_RELEASE;
        end else begin
          state_d = ST_REQ;
        end
      end
      ST_RELEASE: begin
        if (count_zero) begin
          fin     = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_CHECK;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign busy = (state_q != ST_IDLE);

  // R6
  release_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !bus_req);

  // R3
  req_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(dev_ready));

  // R4
  move_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> $past(bus_req));

  // R9
  zero_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && count_zero && !busy) |=> (!bus_req && !busy));
endmodule

// File: rtl/cs_dma_ctrl.sv
`timescale 1ns/1ps
module cs_dma_ctrl import cs_dma_pkg::*; #(
  parameter int DW   = 16,
  parameter int AW   = 16,
  parameter int CW   = 16,
  parameter int DEVW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  output logic [DEVW-1:0]   dev_sel,
  input  logic              dev_ready,
  input  logic [DW-1:0]     dev_rd_data,
  output logic [DW-1:0]     dev_wr_data,
  output logic              dev_strobe,
  output logic              bus_req,
  input  logic              bus_ack,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic              irq
);
  logic          go, dir, busy, xfer, fin;
  logic          ld_addr, ld_count, count_zero;
  logic [AW-1:0] addr_in, cur_addr;
  logic [CW-1:0] count_in, cur_count;

  cs_dma_regs #(.DW(DW), .AW(AW), .CW(CW), .DEVW(DEVW)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .busy(busy), .fin(fin), .cur_addr(cur_addr), .cur_count(cur_count),
    .go(go), .dir(dir), .dev(dev_sel),
    .ld_addr(ld_addr), .ld_count(ld_count), .addr_in(addr_in), .count_in(count_in),
    .irq(irq), .cfg_rdata(cfg_rdata)
  );

  cs_dma_counter #(.AW(AW), .CW(CW)) cnt_i (
    .clk(clk), .rst_n(rst_n),
    .ld_addr(ld_addr), .ld_count(ld_count), .addr_in(addr_in), .count_in(count_in),
    .step(xfer), .cur_addr(cur_addr), .cur_count(cur_count), .count_zero(count_zero)
  );

  cs_dma_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .go(go), .count_zero(count_zero),
    .dev_ready(dev_ready), .bus_ack(bus_ack),
    .busy(busy), .bus_req(bus_req), .xfer(xfer), .fin(fin)
  );

  assign mem_en      = xfer;
  assign mem_we      = xfer && !dir;
  assign mem_addr    = cur_addr;
  assign mem_wdata   = dev_rd_data;
  assign dev_wr_data = mem_rdata;
  assign dev_strobe  = xfer;

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (cur_count == $past(cur_count) - CW'(1)));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (cur_addr == $past(cur_addr) + AW'(1)));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_req && !mem_en));
endmodule

// File: tb/cs_dma_ctrl_tb_top.sv
`timescale 1ns/1ps
module cs_dma_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [3:0]  dev_sel;
  logic        dev_ready = 1'b0;
  logic [15:0] dev_rd_data, dev_wr_data;
  logic        dev_strobe, bus_req, mem_en, mem_we, irq;
  logic        bus_ack = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  int n_chk = 0, n_bad = 0;
  logic [15:0] bmem [0:255];
  int   dev_ptr = 0;
  bit   hold_low = 1'b0;
  bit   x_dir = 1'b0;
  logic [15:0] x_start = '0;
  int   x_k = 0;
  bit   prev_req = 1'b0, prev_en = 1'b0;
  int   own_words = 0;

  always #4 clk = ~clk;

  cs_dma_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dev_sel(dev_sel), .dev_ready(dev_ready),
    .dev_rd_data(dev_rd_data), .dev_wr_data(dev_wr_data), .dev_strobe(dev_strobe),
    .bus_req(bus_req), .bus_ack(bus_ack), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
  );

  function automatic logic [15:0] memval(input logic [15:0] a);
    return 16'h3C00 ^ (a * 16'd37);
  endfunction

  function automatic logic [15:0] devval(input int p);
    return 16'hA000 + 16'(p);
  endfunction

  assign mem_rdata   = bmem[mem_addr[7:0]];
  assign dev_rd_data = devval(dev_ptr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mem_en && mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
    if (dev_strobe) dev_ptr <= dev_ptr + 1;
  end

  always @(negedge clk) begin
    dev_ready <= !hold_low && ($urandom_range(3) != 0);
    bus_ack   <= bus_req && (bus_ack || $urandom_range(2) == 0);
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_req && !prev_req) chk(dev_ready, "R3 req without ready", 32'(dev_ready), 1);
      if (prev_en) chk(!bus_req, "R6 req after word", 32'(bus_req), 0);
      if (mem_en) begin
        chk(bus_ack, "R4 ack during word", 32'(bus_ack), 1);
        chk(mem_addr == x_start + 16'(x_k), "R4 address", 32'(mem_addr), 32'(x_start + 16'(x_k)));
        chk(mem_we == !x_dir, "R4 write enable", 32'(mem_we), 32'(!x_dir));
        chk(dev_strobe, "R4 strobe", 32'(dev_strobe), 1);
        if (!x_dir) chk(mem_wdata == devval(dev_ptr), "R4 write data", 32'(mem_wdata), 32'(devval(dev_ptr)));
        else chk(dev_wr_data == memval(x_start + 16'(x_k)), "R4 read data", 32'(dev_wr_data),
                 32'(memval(x_start + 16'(x_k))));
        x_k++;
        own_words++;
      end
      if (prev_req && !bus_req) begin
        chk(own_words == 1, "R5 words per ownership", 32'(own_words), 1);
        own_words = 0;
      end
      prev_req = bus_req;
      prev_en  = mem_en;
    end
  end

  task automatic cfg_write(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [15:0] d);
    @(posedge clk); #1;
    cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
    @(posedge clk); #1;
    cfg_rd = 1'b0;
  endtask

  task automatic wait_irq(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq) begin seen = 1'b1; break; end
    end
  endtask

  task automatic run_xfer(input bit dir, input logic [3:0] dev, input logic [15:0] start,
                          input int n, input bit poke);
    logic [15:0] rd;
    bit seen;
    cfg_write(3'd1, {12'h0, dev});
    cfg_write(3'd2, start);
    cfg_write(3'd3, 16'(n));
    x_dir = dir; x_start = start; x_k = 0;
    cfg_write(3'd0, {14'h0, dir, 1'b1});
    if (poke) begin
      // R10: writes while busy must be ignored
      cfg_write(3'd3, 16'h0055);
      cfg_write(3'd2, 16'h0011);
      cfg_write(3'd1, 16'h000F);
      cfg_write(3'd0, {14'h0, !dir, 1'b1});
      chk(dev_sel == dev, "R10 peripheral held", 32'(dev_sel), 32'(dev));
    end
    wait_irq(seen);
    chk(seen, "R7 irq raised", 32'(seen), 1);
    chk(x_k == n, "R5 word total", 32'(x_k), 32'(n));
    chk(dev_sel == dev, "R2 peripheral number", 32'(dev_sel), 32'(dev));
    repeat (3) @(negedge clk);
    chk(irq, "R8 irq held", 32'(irq), 1);
    cfg_read(3'd2, rd);
    chk(rd == start + 16'(n), "R7 end address", 32'(rd), 32'(start + 16'(n)));
    cfg_read(3'd3, rd);
    chk(rd == 16'h0, "R7 end count", 32'(rd), 0);
    cfg_read(3'd0, rd);
    chk(rd[1] == dir, "R1 direction readback", 32'(rd[1]), 32'(dir));
    cfg_read(3'd4, rd);
    chk(rd[1:0] == 2'b10, "R7 status done", 32'(rd[1:0]), 2);
    @(negedge clk);
    chk(!irq, "R8 irq cleared by read", 32'(irq), 0);
  endtask

  initial begin
    for (int i = 0; i < 3000000; i++) begin
      @(posedge clk);
      if (i > 150000) break;
    end
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) bmem[i] = memval(16'(i));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!irq && !bus_req && !mem_en, "R11 reset outputs", {29'h0, irq, bus_req, mem_en}, 0);
    cfg_read(3'd4, rd);
    chk(rd == 16'h0, "R11 reset status", 32'(rd), 0);

    // R9 zero count
    cfg_write(3'd3, 16'h0);
    cfg_write(3'd0, 16'h0001);
    @(negedge clk);
    chk(irq, "R9 zero count irq", 32'(irq), 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!bus_req, "R9 no request", 32'(bus_req), 0);
    end
    cfg_read(3'd4, rd);
    chk(rd[1:0] == 2'b10, "R9 status after zero", 32'(rd[1:0]), 2);

    // R3 peripheral held not-ready
    hold_low = 1'b1;
    cfg_write(3'd1, 16'h0003);
    cfg_write(3'd2, 16'h0010);
    cfg_write(3'd3, 16'h0002);
    x_dir = 1'b1; x_start = 16'h0010; x_k = 0;
    cfg_write(3'd0, 16'h0003);
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      chk(!bus_req, "R3 no request while not ready", 32'(bus_req), 0);
    end
    cfg_read(3'd4, rd);
    chk(rd[0] == 1'b1, "R1 busy while waiting", 32'(rd[0]), 1);
    hold_low = 1'b0;
    begin
      bit seen;
      wait_irq(seen);
      chk(seen && x_k == 2, "R7 stalled block ends", 32'(x_k), 2);
      cfg_read(3'd4, rd);
    end

    // directed boundaries
    run_xfer(1'b0, 4'h5, 16'h0080, 1, 1'b0);
    run_xfer(1'b1, 4'h9, 16'h0000, 8, 1'b0);
    run_xfer(1'b0, 4'h2, 16'h00A0, 6, 1'b1);
    run_xfer(1'b1, 4'hC, 16'h0040, 6, 1'b1);

    // random blocks
    for (int t = 0; t < 12; t++) begin
      bit d = 1'($urandom_range(1));
      int n = int'($urandom_range(8, 1));
      logic [15:0] s = d ? 16'($urandom_range(16'h70)) : 16'(16'h80 + $urandom_range(16'h70));
      run_xfer(d, 4'($urandom_range(15)), s, n, 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule